// File: doc/BRIEF.md
# STS-1 Payload Envelope Column Classifier

This block follows the byte position inside an 87-column by 9-row STS-1 synchronous payload envelope and labels every accepted byte time. A byte is tagged as path overhead, fixed stuff or tributary payload. For payload bytes it also reports which interleaved virtual tributary the byte belongs to, as a group number and a number within that group. A transmit multiplexer uses these labels to pick the byte to send from the right tributary.

Column 1 is the path overhead column. Columns 30 and 59 are fixed stuff. The other 84 columns carry tributary data. These payload columns get a running index k from 0 to 83, counted left to right and skipping columns 1, 30 and 59. Payload column k belongs to group (k mod 7)+1. The number within the group is ((k div 7) mod 4)+1 for 1.5 Mbit/s tributaries and ((k div 7) mod 3)+1 for 2 Mbit/s tributaries. A mode input selects between the two.

The labels are combinational and describe the byte that is presented in the same cycle. A start strobe marks the first byte of an envelope. After that the position runs freely and wraps on its own.

Top module: `spe_col_classifier`

## Requirements
- R1: After reset and before the first accepted start strobe, every byte time shows class 0 (idle) and zero on col, row, vt_group and vt_num.
- R2: In a cycle with byte_en low, class is 0 and all position outputs are 0. spe_start is ignored in that cycle, and the position does not advance.
- R3: A cycle with byte_en and spe_start both high is labelled column 1, row 1, class 1 (path overhead).
- R4: Each enabled byte advances the column by one. Column 87 is followed by column 1 of the next row, and row 9 column 87 is followed by row 1 column 1, with no new start strobe needed.
- R5: Columns 30 and 59 are labelled class 2 (fixed stuff).
- R6: All other columns are labelled class 3 (payload), with vt_group = (k mod 7)+1 where k is the payload index.
- R7: With vt2_mode = 0, vt_num = ((k div 7) mod 4)+1. With vt2_mode = 1, vt_num = ((k div 7) mod 3)+1.
- R8: vt_group and vt_num are 0 whenever the class is not 3.
- R9: A start strobe that arrives in the middle of an envelope restarts the labelling at column 1, row 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spe_start | input | 1 | Marks the current byte as the first byte of an envelope |
| byte_en | input | 1 | A byte is present this cycle |
| vt2_mode | input | 1 | 0: 1.5 Mbit/s tributaries (4 per group); 1: 2 Mbit/s tributaries (3 per group) |
| cls | output | 2 | 0 idle, 1 path overhead, 2 fixed stuff, 3 payload |
| col | output | 7 | Envelope column, 1..87 |
| row | output | 4 | Envelope row, 1..9 |
| vt_group | output | 3 | Tributary group, 1..7 |
| vt_num | output | 3 | Tributary within its group, 1..4 |

## Verification
A wrong column or row register shows up at the ports in the same cycle, as a wrong col or row value. It also shows up as a wrong class once the error reaches column 1, 30 or 59. A shifted payload index shows up within one byte as a wrong group number, because the group changes on every payload column. Errors in the within-group number only show when the index crosses a multiple of 7. For this reason the bench sweeps complete envelopes in both modes, with enable gaps, a free-running wrap and a restart in mid-envelope.

// File: rtl/spe_col_classifier.sv
module spe_col_classifier #(
  parameter int COLS    = 87,
  parameter int ROWS    = 9,
  parameter int STUFF_A = 30,
  parameter int STUFF_B = 59,
  parameter int GROUPS  = 7,
  localparam int CW = $clog2(COLS + 1),
  localparam int RW = $clog2(ROWS + 1),
  localparam int GW = $clog2(GROUPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spe_start,
  input  logic          byte_en,
  input  logic          vt2_mode,
  output logic [1:0]    cls,
  output logic [CW-1:0] col,
  output logic [RW-1:0] row,
  output logic [GW-1:0] vt_group,
  output logic [2:0]    vt_num
);

  logic          locked;
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] cur_col, pidx, grp0, blk, vt0;
  logic [RW-1:0] cur_row;
  logic          active, is_poh, is_stuff;

  assign active   = byte_en & (spe_start | locked);
  assign cur_col  = spe_start ? CW'(1) : col_q;
  assign cur_row  = spe_start ? RW'(1) : row_q;
  assign is_poh   = (cur_col == CW'(1));
  assign is_stuff = (cur_col == CW'(STUFF_A)) || (cur_col == CW'(STUFF_B));

  assign pidx = cur_col - CW'(2) - CW'(cur_col > CW'(STUFF_A)) - CW'(cur_col > CW'(STUFF_B));
  assign grp0 = pidx % CW'(GROUPS);
  assign blk  = pidx / CW'(GROUPS);
  assign vt0  = vt2_mode ? (blk % CW'(3)) : (blk % CW'(4));

  always_comb begin
    cls      = 2'd0;
    col      = '0;
    row      = '0;
    vt_group = '0;
    vt_num   = '0;
    if (active) begin
      col = cur_col;
      row = cur_row;
      if (is_poh)        cls = 2'd1;
      else if (is_stuff) cls = 2'd2;
      else begin
        cls      = 2'd3;
        vt_group = GW'(grp0) + GW'(1);
        vt_num   = 3'(vt0) + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      col_q  <= CW'(1);
      row_q  <= RW'(1);
    end else if (active) begin
      locked <= 1'b1;
      if (cur_col == CW'(COLS)) begin
        col_q <= CW'(1);
        row_q <= (cur_row == RW'(ROWS)) ? RW'(1) : cur_row + RW'(1);
      end else begin
        col_q <= cur_col + CW'(1);
        row_q <= cur_row;
      end
    end
  end

endmodule

module spe_col_classifier_chk #(
  parameter int COLS    = 87,
  parameter int STUFF_A = 30,
  parameter int STUFF_B = 59,
  parameter int CW = 7,
  parameter int RW = 4,
  parameter int GW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spe_start,
  input logic          byte_en,
  input logic          vt2_mode,
  input logic [1:0]    cls,
  input logic [CW-1:0] col,
  input logic [RW-1:0] row,
  input logic [GW-1:0] vt_group,
  input logic [2:0]    vt_num
);

  logic          seen;
  logic [CW-1:0] last_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      last_col <= '0;
    end else if (byte_en && cls != 2'd0) begin
      seen     <= 1'b1;
      last_col <= col;
    end
  end

  // R2
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_en |-> (cls == 2'd0 && col == '0 && row == '0));

  // R3
  start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && spe_start) |-> (col == CW'(1) && row == RW'(1) && cls == 2'd1));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en && !spe_start && seen && cls != 2'd0) |->
      (col == ((last_col == CW'(COLS)) ? CW'(1) : last_col + CW'(1))));

  // R5
  stuff_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == 2'd2) |-> (col == CW'(STUFF_A) || col == CW'(STUFF_B)));

  // R7
  vt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == 2'd3) |-> (vt_num >= 3'd1 && vt_num <= (vt2_mode ? 3'd3 : 3'd4)));

  // R8
  no_trib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cls != 2'd3) |-> (vt_group == '0 && vt_num == '0));

endmodule

bind spe_col_classifier spe_col_classifier_chk #(
  .COLS(COLS), .STUFF_A(STUFF_A), .STUFF_B(STUFF_B), .CW(CW), .RW(RW), .GW(GW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spe_start(spe_start), .byte_en(byte_en),
  .vt2_mode(vt2_mode), .cls(cls), .col(col), .row(row),
  .vt_group(vt_group), .vt_num(vt_num)
);

// File: tb/tb_spe_col_classifier.sv
module tb_spe_col_classifier;
  logic clk = 1'b0, rst_n = 1'b0, spe_start = 1'b0, byte_en = 1'b0, vt2_mode = 1'b0;
  logic [1:0] cls;
  logic [6:0] col;
  logic [3:0] row;
  logic [2:0] vt_group, vt_num;

  int checks = 0, errors = 0;
  int ecol = 1, erow = 1, ek = 0;
  bit elock = 1'b0;

  always #4 clk = ~clk;

  spe_col_classifier dut (
    .clk(clk), .rst_n(rst_n), .spe_start(spe_start), .byte_en(byte_en),
    .vt2_mode(vt2_mode), .cls(cls), .col(col), .row(row),
    .vt_group(vt_group), .vt_num(vt_num)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit en, bit st);
    bit act;
    int ecls, eg, ev, epc, epr;
    @(negedge clk);
    byte_en = en; spe_start = st;
    #1;
    act = en && (st || elock);
    if (act && st) begin ecol = 1; erow = 1; end
    if (act && ecol == 1) ek = 0;
    eg = 0; ev = 0; epc = 0; epr = 0;
    if (!act) ecls = 0;
    else begin
      epc = ecol; epr = erow;
      if (ecol == 1) ecls = 1;
      else if (ecol == 30 || ecol == 59) ecls = 2;
      else begin
        ecls = 3;
        eg = (ek % 7) + 1;
        ev = vt2_mode ? ((ek / 7) % 3) + 1 : ((ek / 7) % 4) + 1;
        ek++;
      end
    end
    if (!elock && !act)
      chk(cls == 0 && col == 0, "R1 idle before start", int'(cls), 0);
    else if (!en)
      chk(cls == 0 && col == 0 && row == 0, "R2 disabled byte", int'(cls), 0);
    else if (st)
      chk(cls == 1 && col == 1 && row == 1, "R3/R9 start byte", int'(col), 1);
    else begin
      chk(int'(col) == epc, "R4 column", int'(col), epc);
      chk(int'(row) == epr, "R4 row", int'(row), epr);
      chk(int'(cls) == ecls, ecls == 2 ? "R5 stuff class" : "R6 class", int'(cls), ecls);
    end
    chk(int'(vt_group) == eg, ecls == 3 ? "R6 group" : "R8 group zero", int'(vt_group), eg);
    chk(int'(vt_num) == ev, ecls == 3 ? "R7 vt number" : "R8 vt zero", int'(vt_num), ev);
    if (act) begin
      elock = 1'b1;
      if (ecol == 87) begin ecol = 1; erow = (erow == 9) ? 1 : erow + 1; end
      else ecol++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: enabled bytes before any start stay idle
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    // R2: start without enable is ignored
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    // 1.5 Mbit/s mode: two envelopes, second by free-running wrap (R4)
    vt2_mode = 1'b0;
    step(1'b1, 1'b1);
    for (int i = 1; i < 2 * 783; i++) begin
      if (i % 11 == 0) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
    end
    // 2 Mbit/s mode: one envelope
    vt2_mode = 1'b1;
    step(1'b1, 1'b1);
    for (int i = 1; i < 783; i++) begin
      if (i % 13 == 0) step(1'b0, 1'b1);
      step(1'b1, 1'b0);
    end
    // R9: restart in mid-envelope
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 90; i++) step(1'b1, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule